// File: doc/BRIEF.md
# Dual-Bank Clock Divider with Output Crosspoint

This block turns two incoming clocks into six derived clock outputs. A fast clock, which stands in for a frequency synthesizer's output, and a slower reference clock both arrive as ordinary inputs. The block samples them in its own system clock domain. Two divider banks each pick one of the two as a source. Each bank counts source rising edges modulo a programmable integer N. From that same count it derives a divide-by-N output and two fixed-ratio taps. The first bank provides divide-by-two and divide-by-three taps. The second bank provides divide-by-two and divide-by-four taps.

A crosspoint gives each of the six outputs its own 3-bit source code. A configuration checker finds divide values outside the allowed range, taps whose divisibility rule is not met, and idle banks left at a non-default value. It raises a single error flag and forces every output that relies on an illegal source to stay low. An active-high drive enable lets all six outputs float. An active-low run input puts the block into shutdown.

The configuration inputs are captured only while the synchronous reset is held low. The dividers restart from a known phase after each reset.

Top module: `dual_bank_clock_xbar`

## Requirements
- R1: A divide-by-N output has a period of N source periods, and its high phase lasts (N+1)/2 source periods using integer division, so even N gives a 50% duty cycle.
- R2: A bank divide value below 4 is illegal. Every output selecting any source of that bank stays low, and config_error is 1. Values from 4 to 127 are legal.
- R3: Code 2 selects the bank-1 divide-by-two tap (period 2, high 1 source period). It is legal only when the bank-1 divide value is a multiple of 4. Otherwise the output stays low and config_error is 1.
- R4: Code 3 selects the bank-1 divide-by-three tap (period 3, high 2 source periods). It is legal only when the bank-1 divide value equals 6. Otherwise the output stays low and config_error is 1.
- R5: Code 5 selects the bank-2 divide-by-two tap, which needs a multiple of 4. Code 6 selects the bank-2 divide-by-four tap (period 4, high 2), which needs a multiple of 8. A broken rule holds the output low and sets config_error.
- R6: A bank that no output selects must hold a divide value of 8. Any other value sets config_error but changes no output.
- R7: Select codes are 0 for the reference passed through, 1 for bank-1 divide-by-N, and 4 for bank-2 divide-by-N. Codes 2, 3, 5 and 6 are the taps above. Code 7 is reserved: it drives the output low and raises no error.
- R8: bank_src_ref bit b picks the source of bank b+1. A value of 0 selects fast_clk and 1 selects ref_clk. Each bank's output periods scale with its own source's period.
- R9: While drv_en is 0, all six outputs are high impedance.
- R10: While awake is 0, the divider counts are cleared and all outputs are low. On release, the outputs resume with the configured periods.
- R11: The configuration inputs are captured only while rst_n is 0. Changing them while rst_n is 1 has no effect.
- R12: While rst_n is 0, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state is clocked here |
| rst_n | input | 1 | Synchronous active-low reset; captures configuration |
| fast_clk | input | 1 | Fast source clock, sampled in the clk domain |
| ref_clk | input | 1 | Reference clock, sampled in the clk domain |
| bank1_div | input | 7 | Bank-1 divide value N |
| bank2_div | input | 7 | Bank-2 divide value N |
| bank_src_ref | input | 2 | Per-bank source: 0 fast, 1 reference |
| out_sel | input | 18 | Six 3-bit source codes; output i uses bits 3i+2..3i |
| drv_en | input | 1 | 1 drives the outputs, 0 makes them high impedance |
| awake | input | 1 | 0 enters shutdown |
| clk_out | output | 6 | Derived clock outputs |
| config_error | output | 1 | Illegal divider or tap combination captured |

## Verification
The assertions check several properties on every cycle. Each divider count stays below its divide value and wraps to zero after the last step. Shutdown clears the counts and the outputs. Any output flagged illegal, or given the reserved code, is low on the next cycle. Every flagged output also raises the error flag. The captured configuration never moves outside reset. Periods, high phases, tap ratios, the per-bank source choice, high impedance and resuming after shutdown can only be shown by the bench. The bench measures whole output periods under directed and random configurations and compares them with values computed from the rules.

// File: rtl/clkx_pkg.sv
package clkx_pkg;
  localparam int SEL_W = 3;
  localparam int MIN_DIV = 4;
  localparam int IDLE_DIV = 8;

  typedef enum logic [SEL_W-1:0] {
    SRC_REF   = 3'd0,
    SRC_A_N   = 3'd1,
    SRC_A_HALF = 3'd2,
    SRC_A_ALT = 3'd3,
    SRC_B_N   = 3'd4,
    SRC_B_HALF = 3'd5,
    SRC_B_ALT = 3'd6,
    SRC_NONE  = 3'd7
  } src_code_e;
endpackage

// File: rtl/clkx_edge_sync.sv
module clkx_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic lvl,
  output logic rise
);
  logic s1, s2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= raw;
      s2 <= s1;
    end
  end

  assign lvl  = s1;
  assign rise = s1 & ~s2;
endmodule

// File: rtl/clkx_div_bank.sv
module clkx_div_bank #(
  parameter int DIV_W = 7,
  parameter int ALT_RATIO = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             use_ref,
  input  logic             fast_rise,
  input  logic             ref_rise,
  input  logic [DIV_W-1:0] div_n,
  output logic [2:0]       taps
);
  localparam int CW = DIV_W + 1;

  logic [DIV_W-1:0] cnt;
  logic             step;
  logic [CW-1:0]    cnt_nxt;
  logic [CW-1:0]    high_len;
  logic             tap_alt;

  assign step     = use_ref ? ref_rise : fast_rise;
  assign cnt_nxt  = {1'b0, cnt} + CW'(1);
  assign high_len = ({1'b0, div_n} + CW'(1)) >> 1;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt <= '0;
    end else if (step) begin
      if (cnt_nxt >= {1'b0, div_n}) cnt <= '0;
      else                          cnt <= cnt_nxt[DIV_W-1:0];
    end
  end

  generate
    if (ALT_RATIO == 3) begin : g_alt3
      assign tap_alt = (cnt == DIV_W'(0)) || (cnt == DIV_W'(1)) ||
                       (cnt == DIV_W'(3)) || (cnt == DIV_W'(4));
    end else begin : g_alt4
      assign tap_alt = ~cnt[1];
    end
  endgenerate

  assign taps[0] = ({1'b0, cnt} < high_len);
  assign taps[1] = ~cnt[0];
  assign taps[2] = tap_alt;

  a_r1_cnt_below_n: assert property (@(posedge clk) disable iff (!rst_n)
    (div_n != '0) |-> (cnt < div_n));

  a_r1_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (run && step && div_n != '0 && ({1'b0, cnt} == {1'b0, div_n} - CW'(1)))
      |=> (cnt == '0));

  a_r10_pd_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));
endmodule

// File: rtl/clkx_cfg_check.sv
module clkx_cfg_check
  import clkx_pkg::*;
#(
  parameter int DIV_W = 7,
  parameter int N_OUT = 6
) (
  input  logic [DIV_W-1:0]       div_a,
  input  logic [DIV_W-1:0]       div_b,
  input  logic [N_OUT*SEL_W-1:0] sel,
  output logic [N_OUT-1:0]       bad,
  output logic                   cfg_err
);
  logic ok_a, ok_b, a_m4, a_six, b_m4, b_m8;
  logic used_a, used_b;

  always_comb begin
    ok_a  = (div_a >= DIV_W'(MIN_DIV));
    ok_b  = (div_b >= DIV_W'(MIN_DIV));
    a_m4  = (div_a[1:0] == 2'b00);
    a_six = (div_a == DIV_W'(6));
    b_m4  = (div_b[1:0] == 2'b00);
    b_m8  = (div_b[2:0] == 3'b000);
    used_a = 1'b0;
    used_b = 1'b0;
    for (int i = 0; i < N_OUT; i++) begin
      src_code_e s;
      s = src_code_e'(sel[i*SEL_W +: SEL_W]);
      bad[i] = 1'b0;
      case (s)
        SRC_A_N:    begin used_a = 1'b1; bad[i] = !ok_a; end
        SRC_A_HALF: begin used_a = 1'b1; bad[i] = !ok_a || !a_m4; end
        SRC_A_ALT:  begin used_a = 1'b1; bad[i] = !ok_a || !a_six; end
        SRC_B_N:    begin used_b = 1'b1; bad[i] = !ok_b; end
        SRC_B_HALF: begin used_b = 1'b1; bad[i] = !ok_b || !b_m4; end
        SRC_B_ALT:  begin used_b = 1'b1; bad[i] = !ok_b || !b_m8; end
        default:    bad[i] = 1'b0;
      endcase
    end
    cfg_err = (|bad) ||
              (!used_a && div_a != DIV_W'(IDLE_DIV)) ||
              (!used_b && div_b != DIV_W'(IDLE_DIV));
  end
endmodule

// File: rtl/clkx_xpoint.sv
module clkx_xpoint
  import clkx_pkg::*;
#(
  parameter int N_OUT = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   run,
  input  logic                   ref_lvl,
  input  logic [2:0]             taps_a,
  input  logic [2:0]             taps_b,
  input  logic [N_OUT*SEL_W-1:0] sel,
  input  logic [N_OUT-1:0]       bad,
  output logic [N_OUT-1:0]       out_q
);
  logic [7:0] srcs;
  assign srcs = {1'b0, taps_b, taps_a, ref_lvl};

  generate
    for (genvar i = 0; i < N_OUT; i++) begin : g_out
      logic [SEL_W-1:0] code;
      assign code = sel[i*SEL_W +: SEL_W];

      always_ff @(posedge clk) begin
        if (!rst_n || !run) out_q[i] <= 1'b0;
        else                out_q[i] <= srcs[code] & ~bad[i];
      end

      a_r2_bad_held_low: assert property (@(posedge clk) disable iff (!rst_n)
        bad[i] |=> !out_q[i]);

      a_r7_reserved_low: assert property (@(posedge clk) disable iff (!rst_n)
        (code == SRC_NONE) |=> !out_q[i]);

      a_r10_pd_out_low: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !out_q[i]);
    end
  endgenerate
endmodule

// File: rtl/dual_bank_clock_xbar.sv
module dual_bank_clock_xbar
  import clkx_pkg::*;
#(
  parameter int DIV_W = 7,
  parameter int N_OUT = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fast_clk,
  input  logic                   ref_clk,
  input  logic [DIV_W-1:0]       bank1_div,
  input  logic [DIV_W-1:0]       bank2_div,
  input  logic [1:0]             bank_src_ref,
  input  logic [N_OUT*SEL_W-1:0] out_sel,
  input  logic                   drv_en,
  input  logic                   awake,
  output logic [N_OUT-1:0]       clk_out,
  output logic                   config_error
);
  localparam int SEL_TOT = N_OUT * SEL_W;

  logic [DIV_W-1:0]   div_a_q, div_b_q;
  logic [1:0]         src_q;
  logic [SEL_TOT-1:0] sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_a_q <= bank1_div;
      div_b_q <= bank2_div;
      src_q   <= bank_src_ref;
      sel_q   <= out_sel;
    end
  end

  logic fast_lvl, fast_rise, ref_lvl, ref_rise;

  clkx_edge_sync u_fast (.clk(clk), .rst_n(rst_n), .raw(fast_clk),
                         .lvl(fast_lvl), .rise(fast_rise));
  clkx_edge_sync u_ref  (.clk(clk), .rst_n(rst_n), .raw(ref_clk),
                         .lvl(ref_lvl), .rise(ref_rise));

  logic [2:0] taps_a, taps_b;

  clkx_div_bank #(.DIV_W(DIV_W), .ALT_RATIO(3)) u_bank_a (
    .clk(clk), .rst_n(rst_n), .run(awake), .use_ref(src_q[0]),
    .fast_rise(fast_rise), .ref_rise(ref_rise), .div_n(div_a_q), .taps(taps_a));

  clkx_div_bank #(.DIV_W(DIV_W), .ALT_RATIO(4)) u_bank_b (
    .clk(clk), .rst_n(rst_n), .run(awake), .use_ref(src_q[1]),
    .fast_rise(fast_rise), .ref_rise(ref_rise), .div_n(div_b_q), .taps(taps_b));

  logic [N_OUT-1:0] bad;

  clkx_cfg_check #(.DIV_W(DIV_W), .N_OUT(N_OUT)) u_check (
    .div_a(div_a_q), .div_b(div_b_q), .sel(sel_q), .bad(bad),
    .cfg_err(config_error));

  logic [N_OUT-1:0] out_q;

  clkx_xpoint #(.N_OUT(N_OUT)) u_xp (
    .clk(clk), .rst_n(rst_n), .run(awake), .ref_lvl(ref_lvl),
    .taps_a(taps_a), .taps_b(taps_b), .sel(sel_q), .bad(bad), .out_q(out_q));

  generate
    for (genvar i = 0; i < N_OUT; i++) begin : g_drv
      assign clk_out[i] = drv_en ? out_q[i] : 1'bz;
    end
  endgenerate

  logic unused_lvl;
  assign unused_lvl = fast_lvl;

  a_r11_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ($stable(div_a_q) && $stable(div_b_q) &&
                      $stable(src_q) && $stable(sel_q)));

  a_r6_err_covers_bad: assert property (@(posedge clk) disable iff (!rst_n)
    (|bad) |-> config_error);

  a_r12_reset_low: assert property (@(posedge clk)
    !rst_n |=> (out_q == '0));
endmodule

// File: tb/dual_bank_clock_xbar_tb_top.sv
module dual_bank_clock_xbar_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, fast_clk = 1'b0, ref_clk = 1'b0;
  logic [6:0] bank1_div = 7'd8, bank2_div = 7'd8;
  logic [1:0] bank_src_ref = 2'b00;
  logic [17:0] out_sel = '0;
  logic drv_en = 1'b1, awake = 1'b1;
  wire  [5:0] clk_out;
  wire  config_error;

  dual_bank_clock_xbar dut_i (
    .clk(clk), .rst_n(rst_n), .fast_clk(fast_clk), .ref_clk(ref_clk),
    .bank1_div(bank1_div), .bank2_div(bank2_div), .bank_src_ref(bank_src_ref),
    .out_sel(out_sel), .drv_en(drv_en), .awake(awake),
    .clk_out(clk_out), .config_error(config_error));

  // fast source: period 2 clk; reference: period 6 clk
  int ref_ph = 0;
  always @(negedge clk) begin
    fast_clk <= ~fast_clk;
    ref_ph = (ref_ph == 2) ? 0 : ref_ph + 1;
    if (ref_ph == 0) ref_clk <= ~ref_clk;
  end

  int checks = 0, fails = 0;
  int n1, n2;
  bit s1, s2;
  int sel[6];

  initial begin
    repeat (190000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit sel_bad(int s);
    bit r1 = n1 >= 4, r2 = n2 >= 4;
    case (s)
      1: return !r1;
      2: return !r1 || (n1 % 4 != 0);
      3: return !r1 || (n1 != 6);
      4: return !r2;
      5: return !r2 || (n2 % 4 != 0);
      6: return !r2 || (n2 % 8 != 0);
      default: return 0;
    endcase
  endfunction

  function automatic bit exp_err();
    bit u1 = 0, u2 = 0, e = 0;
    for (int i = 0; i < 6; i++) begin
      e |= sel_bad(sel[i]);
      if (sel[i] >= 1 && sel[i] <= 3) u1 = 1;
      if (sel[i] >= 4 && sel[i] <= 6) u2 = 1;
    end
    if (!u1 && n1 != 8) e = 1;
    if (!u2 && n2 != 8) e = 1;
    return e;
  endfunction

  function automatic int exp_per(int s, bit high);
    int sp1 = s1 ? 6 : 2, sp2 = s2 ? 6 : 2;
    case (s)
      0: return high ? 3 : 6;
      1: return high ? ((n1 + 1) / 2) * sp1 : n1 * sp1;
      2: return high ? sp1 : 2 * sp1;
      3: return high ? 2 * sp1 : 3 * sp1;
      4: return high ? ((n2 + 1) / 2) * sp2 : n2 * sp2;
      5: return high ? sp2 : 2 * sp2;
      default: return high ? 2 * sp2 : 4 * sp2;
    endcase
  endfunction

  task automatic apply_cfg(int a, int b, bit x1, bit x2, int s0, int s1v,
                           int s2v, int s3, int s4, int s5);
    n1 = a; n2 = b; s1 = x1; s2 = x2;
    sel[0] = s0; sel[1] = s1v; sel[2] = s2v; sel[3] = s3; sel[4] = s4; sel[5] = s5;
    @(negedge clk);
    bank1_div = 7'(a); bank2_div = 7'(b); bank_src_ref = {x2, x1};
    for (int i = 0; i < 6; i++) out_sel[i*3 +: 3] = 3'(sel[i]);
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  task automatic measure(int idx, string req);
    int hi = 0, lo = 0, guard = 0;
    int ep = exp_per(sel[idx], 0), eh = exp_per(sel[idx], 1);
    while (clk_out[idx] !== 1'b0 && guard < 2000) begin @(negedge clk); guard++; end
    while (clk_out[idx] !== 1'b1 && guard < 2000) begin @(negedge clk); guard++; end
    while (clk_out[idx] === 1'b1 && guard < 2000) begin @(negedge clk); hi++; guard++; end
    while (clk_out[idx] === 1'b0 && guard < 2000) begin @(negedge clk); lo++; guard++; end
    chk(hi + lo == ep, {req, " period"}, hi + lo, ep);
    chk(hi == eh, {req, " high phase"}, hi, eh);
  endtask

  task automatic check_low(int idx, string req);
    int seen = 0;
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      if (clk_out[idx] !== 1'b0) seen++;
    end
    chk(seen == 0, {req, " held low"}, seen, 0);
  endtask

  task automatic check_err(string req);
    chk(config_error == exp_err(), {req, " config_error"}, int'(config_error), int'(exp_err()));
  endtask

  task automatic check_all(string req);
    check_err(req);
    for (int i = 0; i < 6; i++)
      if (sel[i] == 7 || sel_bad(sel[i])) check_low(i, req);
      else measure(i, req);
  endtask

  initial begin
    void'($urandom(32'd20251));
    // R12: reset state
    repeat (3) @(negedge clk);
    chk(clk_out === 6'b0, "R12 reset outputs", int'(clk_out), 0);
    // R1 R7 R8: even/odd N, ref passthrough, reserved code
    apply_cfg(7, 10, 0, 1, 1, 4, 0, 7, 1, 4);
    check_all("R1 R7 R8");
    // R4 R3 R5: legal taps
    apply_cfg(6, 16, 1, 0, 3, 1, 5, 6, 4, 0);
    check_all("R4 R5");
    apply_cfg(12, 8, 0, 1, 2, 1, 6, 5, 3, 0);
    check_all("R3 R4 R5");
    // R2: range violation on bank 1
    apply_cfg(3, 8, 0, 0, 1, 2, 0, 7, 0, 0);
    check_all("R2");
    // R6: idle bank not 8 -> error, outputs unaffected
    apply_cfg(8, 9, 0, 0, 1, 0, 1, 0, 2, 7);
    check_all("R6");
    // R9: high impedance
    @(negedge clk); drv_en = 1'b0;
    repeat (2) @(negedge clk);
    chk(clk_out === 6'bzzzzzz, "R9 hi-z", int'(clk_out), 0);
    drv_en = 1'b1;
    // R10: shutdown and restart
    apply_cfg(10, 8, 0, 0, 1, 0, 1, 1, 2, 0);
    @(negedge clk); awake = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 6; i++) check_low(i, "R10 shutdown");
    awake = 1'b1;
    repeat (10) @(negedge clk);
    measure(0, "R10 restart");
    measure(1, "R10 restart");
    // R11: change config without reset
    @(negedge clk);
    bank1_div = 7'd20; out_sel = '0; bank_src_ref = 2'b11;
    repeat (10) @(negedge clk);
    measure(0, "R11 ignored");
    check_err("R11");
    // random configurations
    for (int k = 0; k < 6; k++) begin
      int a = 4 + int'($urandom % 37);
      int b = ($urandom % 2 == 1) ? 8 * (1 + int'($urandom % 5)) : 4 + int'($urandom % 37);
      if ($urandom % 4 == 0) a = 6;
      apply_cfg(a, b, 1'($urandom), 1'($urandom), int'($urandom % 8), int'($urandom % 8),
                int'($urandom % 8), int'($urandom % 8), int'($urandom % 8),
                int'($urandom % 8));
      check_all("R1-random R2 R3 R4 R5 R7");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule